// File: doc/BRIEF.md
# Status Stack Pointer Controller

This block owns the pointer that describes a word-addressed status stack in memory: a top-of-stack address, a 15-bit space count, a 15-bit word count and a sticky overflow flag for each count. It runs whole frames of a fixed number of words (28 by default) in either direction. A push stores a frame at rising addresses. A pull reads the same frame back, newest word first. For every word it presents one address on a valid/ready memory port, and it keeps the pointer fields current as each word is accepted.

When idle, software-style control can load all five pointer fields in one cycle through the direct-write inputs. A pull whose word count is zero does not touch the stack. Instead it raises a one-cycle request to fetch default status words from real locations 2 and 3. A pull with a nonzero word count smaller than one frame raises an instruction-exception trap. Frame contents, address translation and trap handling belong to the surrounding logic.

The memory port follows valid/ready rules. Once `mem_valid` is high, it stays high with `mem_addr` and `mem_write` unchanged until a cycle in which `mem_ready` is high. A word transfers on each clock edge that sees both signals high. The sink may hold `mem_ready` low for any number of cycles, and no word is lost or repeated.

Top module: `ssp_ctrl`

## Requirements
- R1: After reset, all pointer fields and both flags are zero, and `busy`, `mem_valid`, `done`, `trap`, `trap_cc2` and `dflt_load` are low.
- R2: While idle, `dw_en` loads the address, both counts and both flags on the next clock edge, and can clear a set flag. While a frame is in progress, `dw_en` has no effect. A push or pull command in the same cycle as `dw_en` is ignored.
- R3: A push issues 28 write transfers (`mem_write`=1) at addresses top+1 through top+28 in rising order. It leaves the top at top+28, the word count 28 higher and the space count 28 lower, and `done` is high only in the cycle the 28th word is accepted.
- R4: A word-count increment from 32767 wraps the count to 0 and sets the word-count overflow flag. The push runs to completion, and the decrements of a later pull do not clear that flag.
- R5: A pull whose starting word count is 28 or more issues 28 read transfers (`mem_write`=0) at addresses top, top-1, ... top-27. It leaves the top 28 lower, the word count 28 lower and the space count 28 higher, and `done` marks the last accepted word.
- R6: A space-count increment from 32767 wraps the count to 0 and sets the space-count overflow flag. The pull runs to completion, and the decrements of a later push do not clear that flag.
- R7: A pull with a starting word count of 0 makes no memory transfer and changes no pointer field. It pulses `dflt_load` high for exactly one cycle, in the cycle after the command.
- R8: A pull with a starting word count from 1 to 27 makes no memory transfer and changes no pointer field. In the cycle after the command, it pulses `trap` and `trap_cc2` for one cycle, with `trap_vec` = 0x4D.
- R9: A stalled transfer keeps `mem_valid`, `mem_addr` and `mem_write` steady until `mem_ready`. The address order and counts are the same with or without stalls.
- R10: Commands that arrive while a frame is in progress are ignored. If push and pull are asserted together while idle, the push wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dw_en | input | 1 | Direct write of all pointer fields |
| dw_tos | input | ADDR_W | Top-of-stack value to load |
| dw_space | input | CNT_W | Space count to load |
| dw_words | input | CNT_W | Word count to load |
| dw_space_ovf | input | 1 | Space overflow flag to load |
| dw_words_ovf | input | 1 | Word overflow flag to load |
| cmd_push | input | 1 | Start a push frame |
| cmd_pull | input | 1 | Start a pull frame |
| ptr_tos | output | ADDR_W | Current top-of-stack address |
| ptr_space | output | CNT_W | Current space count |
| ptr_words | output | CNT_W | Current word count |
| ptr_space_ovf | output | 1 | Sticky space-count overflow |
| ptr_words_ovf | output | 1 | Sticky word-count overflow |
| busy | output | 1 | A frame is in progress |
| mem_valid | output | 1 | Memory transfer request |
| mem_write | output | 1 | 1 = store (push), 0 = load (pull) |
| mem_addr | output | ADDR_W | Word address of the transfer |
| mem_ready | input | 1 | Memory accepts the transfer |
| done | output | 1 | Last word of the frame accepted this cycle |
| trap | output | 1 | Short-frame pull trap pulse |
| trap_vec | output | 8 | Trap vector, 0x4D while trap is high |
| trap_cc2 | output | 1 | Trap condition code bit 2 pulse |
| dflt_load | output | 1 | Request to load default status words |

## Verification
The checker assumes that reset is held for at least one clock edge and that the memory sink drives `mem_ready` as a plain level that depends on nothing inside the block. The hold and step properties rely on that. The flag persistence properties assume `dw_en` is the only way the environment can change a flag, so they are qualified by `dw_en` being low. The bench drives `mem_ready` with fixed patterns, either always ready or stalled every third cycle. It changes commands and direct writes only at falling edges. It also deliberately holds `dw_en` and `cmd_pull` high during a push, to show that they are refused.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_PUSH = 2'd1,
    SEQ_PULL = 2'd2
  } seq_state_e;

  typedef enum logic [1:0] {
    PULL_DEFAULT = 2'd0,
    PULL_TRAP    = 2'd1,
    PULL_FRAME   = 2'd2
  } pull_kind_e;

  function automatic pull_kind_e classify_pull(input int unsigned words,
                                               input int unsigned frame);
    if (words == 0)          return PULL_DEFAULT;
    else if (words < frame)  return PULL_TRAP;
    else                     return PULL_FRAME;
  endfunction

endpackage

// File: rtl/ssp_cnt.sv
module ssp_cnt #(
  parameter int W = 15
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         ld_flag,
  input  logic         inc,
  input  logic         dec,
  output logic [W-1:0] cnt,
  output logic         flag
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      flag <= 1'b0;
    end else if (ld) begin
      cnt  <= ld_val;
      flag <= ld_flag;
    end else if (inc) begin
      if (cnt == TOP) begin
        cnt  <= '0;
        flag <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else if (dec) begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/ssp_tos.sv
module ssp_tos #(
  parameter int AW = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic [AW-1:0] ld_val,
  input  logic          up,
  input  logic          down,
  output logic [AW-1:0] tos,
  output logic [AW-1:0] next_up
);
  assign next_up = tos + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n)    tos <= '0;
    else if (ld)   tos <= ld_val;
    else if (up)   tos <= next_up;
    else if (down) tos <= tos - 1'b1;
  end
endmodule

// File: rtl/ssp_seq.sv
module ssp_seq
  import ssp_pkg::*;
#(
  parameter int FRAME = 28,
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_push,
  input  logic             start_pull,
  input  logic [CNT_W-1:0] words,
  input  logic             mem_ready,
  output logic             busy,
  output logic             pushing,
  output logic             mem_valid,
  output logic             beat_acc,
  output logic             done,
  output logic             trap_p,
  output logic             dflt_p
);
  localparam int BEAT_W = (FRAME > 1) ? $clog2(FRAME) : 1;
  localparam logic [BEAT_W-1:0] LAST = BEAT_W'(FRAME - 1);

  seq_state_e        state;
  logic [BEAT_W-1:0] beat;
  pull_kind_e        kind;

  assign kind      = classify_pull(int'(words), FRAME);
  assign busy      = (state != SEQ_IDLE);
  assign pushing   = (state == SEQ_PUSH);
  assign mem_valid = busy;
  assign beat_acc  = mem_valid & mem_ready;
  assign done      = beat_acc & (beat == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= SEQ_IDLE;
      beat   <= '0;
      trap_p <= 1'b0;
      dflt_p <= 1'b0;
    end else begin
      trap_p <= 1'b0;
      dflt_p <= 1'b0;
      case (state)
        SEQ_IDLE: begin
          beat <= '0;
          if (start_push) begin
            state <= SEQ_PUSH;
          end else if (start_pull) begin
            case (kind)
              PULL_DEFAULT: dflt_p <= 1'b1;
              PULL_TRAP:    trap_p <= 1'b1;
              default:      state  <= SEQ_PULL;
            endcase
          end
        end
        default: begin
          if (beat_acc) begin
            if (beat == LAST) begin
              state <= SEQ_IDLE;
              beat  <= '0;
            end else begin
              beat <= beat + 1'b1;
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/ssp_ctrl.sv
module ssp_ctrl #(
  parameter int          ADDR_W      = 17,
  parameter int          CNT_W       = 15,
  parameter int          FRAME       = 28,
  parameter logic [7:0]  TRAP_VECTOR = 8'h4D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dw_en,
  input  logic [ADDR_W-1:0] dw_tos,
  input  logic [CNT_W-1:0]  dw_space,
  input  logic [CNT_W-1:0]  dw_words,
  input  logic              dw_space_ovf,
  input  logic              dw_words_ovf,
  input  logic              cmd_push,
  input  logic              cmd_pull,
  output logic [ADDR_W-1:0] ptr_tos,
  output logic [CNT_W-1:0]  ptr_space,
  output logic [CNT_W-1:0]  ptr_words,
  output logic              ptr_space_ovf,
  output logic              ptr_words_ovf,
  output logic              busy,
  output logic              mem_valid,
  output logic              mem_write,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ready,
  output logic              done,
  output logic              trap,
  output logic [7:0]        trap_vec,
  output logic              trap_cc2,
  output logic              dflt_load
);
  logic              dw_take;
  logic              beat_acc;
  logic              pushing;
  logic              step_push;
  logic              step_pull;
  logic [ADDR_W-1:0] tos_plus;

  assign dw_take   = dw_en & ~busy;
  assign step_push = beat_acc & pushing;
  assign step_pull = beat_acc & ~pushing;

  ssp_seq #(.FRAME(FRAME), .CNT_W(CNT_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_push (cmd_push & ~dw_en),
    .start_pull (cmd_pull & ~dw_en),
    .words      (ptr_words),
    .mem_ready  (mem_ready),
    .busy       (busy),
    .pushing    (pushing),
    .mem_valid  (mem_valid),
    .beat_acc   (beat_acc),
    .done       (done),
    .trap_p     (trap),
    .dflt_p     (dflt_load)
  );

  ssp_tos #(.AW(ADDR_W)) u_tos (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld      (dw_take),
    .ld_val  (dw_tos),
    .up      (step_push),
    .down    (step_pull),
    .tos     (ptr_tos),
    .next_up (tos_plus)
  );

  ssp_cnt #(.W(CNT_W)) u_words (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld      (dw_take),
    .ld_val  (dw_words),
    .ld_flag (dw_words_ovf),
    .inc     (step_push),
    .dec     (step_pull),
    .cnt     (ptr_words),
    .flag    (ptr_words_ovf)
  );

  ssp_cnt #(.W(CNT_W)) u_space (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld      (dw_take),
    .ld_val  (dw_space),
    .ld_flag (dw_space_ovf),
    .inc     (step_pull),
    .dec     (step_push),
    .cnt     (ptr_space),
    .flag    (ptr_space_ovf)
  );

  assign mem_write = pushing;
  assign mem_addr  = pushing ? tos_plus : ptr_tos;
  assign trap_cc2  = trap;
  assign trap_vec  = trap ? TRAP_VECTOR : 8'h00;
endmodule

// File: rtl/ssp_ctrl_chk.sv
module ssp_ctrl_chk #(
  parameter int ADDR_W = 17,
  parameter int CNT_W  = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dw_en,
  input logic [ADDR_W-1:0] ptr_tos,
  input logic [CNT_W-1:0]  ptr_space,
  input logic [CNT_W-1:0]  ptr_words,
  input logic              ptr_space_ovf,
  input logic              ptr_words_ovf,
  input logic              mem_valid,
  input logic              mem_write,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ready,
  input logic              done,
  input logic              trap,
  input logic              dflt_load
);
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_write));

  assert_words_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_words_ovf && !dw_en |=> ptr_words_ovf);

  assert_space_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_space_ovf && !dw_en |=> ptr_space_ovf);

  assert_push_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_ready && mem_write |=> ptr_tos == $past(mem_addr));

  assert_pull_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_ready && !mem_write |=> ptr_tos == $past(mem_addr) - 1'b1);

  assert_done_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> mem_valid && mem_ready);

  assert_trap_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    trap |-> !mem_valid && !dflt_load && $stable(ptr_words) && $stable(ptr_space)
             && $stable(ptr_tos));

  assert_dflt_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dflt_load |-> !mem_valid && $stable(ptr_words) && $stable(ptr_space)
                  && $stable(ptr_tos));
endmodule

bind ssp_ctrl ssp_ctrl_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .dw_en         (dw_en),
  .ptr_tos       (ptr_tos),
  .ptr_space     (ptr_space),
  .ptr_words     (ptr_words),
  .ptr_space_ovf (ptr_space_ovf),
  .ptr_words_ovf (ptr_words_ovf),
  .mem_valid     (mem_valid),
  .mem_write     (mem_write),
  .mem_addr      (mem_addr),
  .mem_ready     (mem_ready),
  .done          (done),
  .trap          (trap),
  .dflt_load     (dflt_load)
);

// File: tb/ssp_ctrl_bench.sv
module ssp_ctrl_bench;
  localparam int AW = 17;
  localparam int CW = 15;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          dw_en = 1'b0;
  logic [AW-1:0] dw_tos = '0;
  logic [CW-1:0] dw_space = '0;
  logic [CW-1:0] dw_words = '0;
  logic          dw_space_ovf = 1'b0;
  logic          dw_words_ovf = 1'b0;
  logic          cmd_push = 1'b0;
  logic          cmd_pull = 1'b0;
  logic [AW-1:0] ptr_tos;
  logic [CW-1:0] ptr_space;
  logic [CW-1:0] ptr_words;
  logic          ptr_space_ovf;
  logic          ptr_words_ovf;
  logic          busy;
  logic          mem_valid;
  logic          mem_write;
  logic [AW-1:0] mem_addr;
  logic          mem_ready = 1'b0;
  logic          done;
  logic          trap;
  logic [7:0]    trap_vec;
  logic          trap_cc2;
  logic          dflt_load;

  int total = 0;
  int fails = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  ssp_ctrl u_ssp_ctrl (
    .clk(clk), .rst_n(rst_n), .dw_en(dw_en), .dw_tos(dw_tos), .dw_space(dw_space),
    .dw_words(dw_words), .dw_space_ovf(dw_space_ovf), .dw_words_ovf(dw_words_ovf),
    .cmd_push(cmd_push), .cmd_pull(cmd_pull), .ptr_tos(ptr_tos), .ptr_space(ptr_space),
    .ptr_words(ptr_words), .ptr_space_ovf(ptr_space_ovf), .ptr_words_ovf(ptr_words_ovf),
    .busy(busy), .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
    .mem_ready(mem_ready), .done(done), .trap(trap), .trap_vec(trap_vec),
    .trap_cc2(trap_cc2), .dflt_load(dflt_load)
  );

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 150000) begin
      total = total + 1;
      fails = fails + 1;
      $display("FAIL watchdog: actual %0d cycles, expected completion", cycles);
      summary();
      $finish;
    end
  end

  task automatic check(input string req, input string what,
                       input longint act, input longint exp);
    total = total + 1;
    if (act != exp) begin
      fails = fails + 1;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_ptr(input string req, input int tos, input int space,
                           input int words, input int sovf, input int wovf);
    check(req, "tos", ptr_tos, tos);
    check(req, "space", ptr_space, space);
    check(req, "words", ptr_words, words);
    check(req, "space_ovf", ptr_space_ovf, sovf);
    check(req, "words_ovf", ptr_words_ovf, wovf);
  endtask

  task automatic direct_write(input int tos, input int space, input int words,
                              input bit sovf, input bit wovf);
    @(negedge clk);
    dw_en = 1'b1; dw_tos = AW'(tos); dw_space = CW'(space); dw_words = CW'(words);
    dw_space_ovf = sovf; dw_words_ovf = wovf;
    @(negedge clk);
    dw_en = 1'b0;
  endtask

  task automatic issue(input bit push, input bit pull);
    @(negedge clk);
    cmd_push = push; cmd_pull = pull;
    @(negedge clk);
    cmd_push = 1'b0; cmd_pull = 1'b0;
  endtask

  // Drives the memory side of one frame from a falling edge with the frame running.
  task automatic run_frame(input string req, input bit push, input bit stall,
                           input int first_addr);
    int acc = 0;
    int cyc = 0;
    int dones = 0;
    int bad = 0;
    int exp_addr = first_addr;
    while (acc < 28 && cyc < 300) begin
      mem_ready = stall ? ((cyc % 3) != 2) : 1'b1;
      #1;
      if (!mem_valid) bad++;
      if (mem_valid && mem_ready) begin
        if (int'(mem_addr) != exp_addr) bad++;
        if (mem_write != push) bad++;
        if (done != (acc == 27)) bad++;
        dones += int'(done);
        acc++;
        exp_addr = push ? exp_addr + 1 : exp_addr - 1;
      end else if (done) begin
        bad++;
      end
      @(negedge clk);
      cyc++;
    end
    mem_ready = 1'b0;
    check(req, "words transferred", acc, 28);
    check(req, "address/direction/done mismatches", bad, 0);
    check(req, "done pulses", dones, 1);
    check(req, "busy after frame", busy, 0);
  endtask

  task automatic t_reset();
    check_ptr("R1", 0, 0, 0, 0, 0);
    check("R1", "busy", busy, 0);
    check("R1", "mem_valid", mem_valid, 0);
    check("R1", "trap/cc2/dflt/done", {trap, trap_cc2, dflt_load, done}, 0);
  endtask

  task automatic t_push_pull();
    direct_write(100, 500, 10, 1'b0, 1'b0);
    check_ptr("R2", 100, 500, 10, 0, 0);
    issue(1'b1, 1'b0);
    run_frame("R3", 1'b1, 1'b0, 101);
    check_ptr("R3", 128, 472, 38, 0, 0);
    issue(1'b0, 1'b1);
    run_frame("R5_R9", 1'b0, 1'b1, 128);
    check_ptr("R5", 100, 500, 10, 0, 0);
  endtask

  task automatic t_short_pull();
    issue(1'b0, 1'b1);
    check("R8", "trap", trap, 1);
    check("R8", "trap_cc2", trap_cc2, 1);
    check("R8", "trap_vec", trap_vec, 8'h4D);
    check("R8", "mem_valid", mem_valid, 0);
    check("R8", "dflt_load", dflt_load, 0);
    @(negedge clk);
    check("R8", "trap one cycle", trap, 0);
    check("R8", "busy", busy, 0);
    check_ptr("R8", 100, 500, 10, 0, 0);
  endtask

  task automatic t_empty_pull();
    direct_write(64, 700, 0, 1'b0, 1'b0);
    issue(1'b0, 1'b1);
    check("R7", "dflt_load", dflt_load, 1);
    check("R7", "trap", trap, 0);
    check("R7", "mem_valid", mem_valid, 0);
    @(negedge clk);
    check("R7", "dflt_load one cycle", dflt_load, 0);
    check("R7", "mem_valid", mem_valid, 0);
    check_ptr("R7", 64, 700, 0, 0, 0);
  endtask

  task automatic t_words_ovf();
    direct_write(300, 2000, 32760, 1'b0, 1'b0);
    issue(1'b1, 1'b0);
    run_frame("R4", 1'b1, 1'b1, 301);
    check_ptr("R4", 328, 1972, 20, 0, 1);
    direct_write(300, 2000, 40, 1'b0, 1'b1);
    issue(1'b0, 1'b1);
    run_frame("R4", 1'b0, 1'b0, 300);
    check_ptr("R4", 272, 2028, 12, 0, 1);
  endtask

  task automatic t_space_ovf();
    direct_write(500, 32750, 50, 1'b0, 1'b0);
    issue(1'b0, 1'b1);
    run_frame("R6", 1'b0, 1'b1, 500);
    check_ptr("R6", 472, 10, 22, 1, 0);
    issue(1'b1, 1'b0);
    run_frame("R6", 1'b1, 1'b0, 473);
    check_ptr("R6", 500, 32750, 50, 1, 0);
    direct_write(500, 32750, 50, 1'b0, 1'b0);
    check_ptr("R2", 500, 32750, 50, 0, 0);
  endtask

  task automatic t_busy_ignore();
    direct_write(200, 1000, 30, 1'b0, 1'b0);
    issue(1'b1, 1'b1);
    check("R10", "push wins (mem_write)", mem_write, 1);
    dw_en = 1'b1; dw_tos = AW'(7); dw_space = CW'(7); dw_words = CW'(7);
    dw_space_ovf = 1'b1; dw_words_ovf = 1'b1;
    cmd_pull = 1'b1;
    run_frame("R10", 1'b1, 1'b1, 201);
    dw_en = 1'b0; cmd_pull = 1'b0;
    check_ptr("R2", 228, 972, 58, 0, 0);
    @(negedge clk);
    check("R10", "no pull started", busy, 0);
    // command together with direct write is dropped
    @(negedge clk);
    dw_en = 1'b1; dw_tos = AW'(40); dw_space = CW'(90); dw_words = CW'(60);
    dw_space_ovf = 1'b0; dw_words_ovf = 1'b0; cmd_push = 1'b1;
    @(negedge clk);
    dw_en = 1'b0; cmd_push = 1'b0;
    check("R2", "command with dw ignored", busy, 0);
    check_ptr("R2", 40, 90, 60, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_push_pull();
    t_short_pull();
    t_empty_pull();
    t_words_ovf();
    t_space_ovf();
    t_busy_ignore();
    repeat (2) @(negedge clk);
    summary();
    $finish;
  end
endmodule